// File: doc/BRIEF.md
# Loadable Serializer with Clock Inhibit

An eight-stage shift register that turns a parallel word into a serial bit stream. Pulling the active-low load control down copies the parallel inputs into every stage at once, without waiting for a clock edge. While the load control is held low, the register keeps tracking the parallel inputs and every clock edge is ignored. Releasing the load control lets the word march toward the last stage, one position per rising clock edge. Bit 7 of the word leaves first.

A clock-inhibit input stops the register without touching the clock. The block treats it as if it were ORed into the clock: while it is high, no edge takes effect. In the RTL it is a synchronous enable. It should change only while the clock is high, as a real gated clock would need. A serial input feeds the first stage, so the register also works as a serial-in, serial-out delay line. The last stage drives a true serial output and a complemented one.

Top module: `piso_shifter`

## Requirements
- R1: While the load control `load_n` is low, `ser_out` equals `par_in[7]` with no clock edge needed, and it follows changes on `par_in` at once.
- R2: Rising clock edges that occur while `load_n` is low cause no shift. After release, the register holds the parallel word present at the last such edge, or at the falling edge of `load_n` if no edge came after it.
- R3: With `load_n` high and `clk_inhibit` low, each rising edge moves every stage one step toward stage 7, so after a load `ser_out` presents D7, then D6, and so on down to D0.
- R4: On each enabled shift edge, stage 0 takes `ser_in`. A bit applied before enabled edge n appears on `ser_out` after enabled edge n+7.
- R5: With `load_n` high and `clk_inhibit` high, rising edges change nothing and `ser_out` stays stable.
- R6: `ser_out_n` is always the inverse of `ser_out`.
- R7: After a load, eight enabled edges shift every loaded bit out. With `ser_in` held at a value v, `ser_out` then shows v.
- R8: A load takes effect whatever the level on `clk_inhibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| load_n | input | 1 | Low: asynchronous, level-sensitive parallel load; high: shift mode |
| clk_inhibit | input | 1 | High blocks shift edges |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel word; bit 7 is the first to leave |
| ser_out | output | 1 | Last-stage value, or `par_in[7]` while loading |
| ser_out_n | output | 1 | Complement of `ser_out` |

## Verification
Two functions can meet in one cycle: a load held low across a rising edge, and a shift that the same edge would otherwise perform. The bench drops `load_n` with `clk_inhibit` both low and high and keeps it low across several edges. It then releases it and judges that the first bit out is the loaded D7 and not a shifted value. A second pairing, inhibit against an active shift, is provoked by toggling `clk_inhibit` mid-stream. Each cycle is then compared with a queue model that only advances on enabled edges.

// File: rtl/piso_pkg.sv
package piso_pkg;
  localparam int unsigned PISO_WIDTH = 8;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_HOLD  = 2'd2
  } piso_op_e;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic     load_n,
  input  logic     clk_inhibit,
  output piso_op_e op,
  output logic     shift_en
);
  always_comb begin
    if (!load_n)          op = OP_LOAD;
    else if (clk_inhibit) op = OP_HOLD;
    else                  op = OP_SHIFT;
  end

  assign shift_en = (op == OP_SHIFT);
endmodule

// File: rtl/piso_stage.sv
module piso_stage (
  input  logic clk,
  input  logic load_n,
  input  logic shift_en,
  input  logic par_bit,
  input  logic prev_bit,
  output logic q
);
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)       q <= par_bit;
    else if (shift_en) q <= prev_bit;
  end
endmodule

// File: rtl/piso_out.sv
module piso_out
  import piso_pkg::*;
(
  input  piso_op_e op,
  input  logic     last_stage,
  input  logic     par_top,
  output logic     ser_out,
  output logic     ser_out_n
);
  logic view;

  always_comb begin
    if (op == OP_LOAD) view = par_top;
    else               view = last_stage;
  end

  assign ser_out   = view;
  assign ser_out_n = ~view;
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = PISO_WIDTH
) (
  input  logic             clk,
  input  logic             load_n,
  input  logic             clk_inhibit,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  localparam int unsigned LAST = WIDTH - 1;

  piso_op_e         op;
  logic             shift_en;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;

  piso_ctrl u_ctrl (
    .load_n      (load_n),
    .clk_inhibit (clk_inhibit),
    .op          (op),
    .shift_en    (shift_en)
  );

  assign stage_d = {stage_q[LAST-1:0], ser_in};

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    piso_stage u_stage (
      .clk      (clk),
      .load_n   (load_n),
      .shift_en (shift_en),
      .par_bit  (par_in[i]),
      .prev_bit (stage_d[i]),
      .q        (stage_q[i])
    );
  end

  piso_out u_out (
    .op         (op),
    .last_stage (stage_q[LAST]),
    .par_top    (par_in[LAST]),
    .ser_out    (ser_out),
    .ser_out_n  (ser_out_n)
  );
endmodule

// File: rtl/piso_shifter_chk.sv
module piso_shifter_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             load_n,
  input logic             clk_inhibit,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] stage_q,
  input logic             ser_out,
  input logic             ser_out_n
);
  logic primed = 1'b0;

  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) primed <= 1'b1;
  end

  a_r1_load_view: assert property (@(posedge clk) disable iff (!primed)
    !load_n |-> ser_out == par_in[WIDTH-1]);

  a_r3_stage_advance: assert property (@(posedge clk) disable iff (!load_n || !primed)
    !clk_inhibit |=> stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0]));

  a_r4_serial_entry: assert property (@(posedge clk) disable iff (!load_n || !primed)
    !clk_inhibit |=> stage_q[0] == $past(ser_in));

  a_r5_inhibit_freeze: assert property (@(posedge clk) disable iff (!load_n || !primed)
    clk_inhibit |=> $stable(stage_q) && $stable(ser_out));

  a_r6_complement: assert property (@(posedge clk) disable iff (!primed)
    ser_out_n != ser_out);
endmodule

bind piso_shifter piso_shifter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .load_n      (load_n),
  .clk_inhibit (clk_inhibit),
  .ser_in      (ser_in),
  .par_in      (par_in),
  .stage_q     (stage_q),
  .ser_out     (ser_out),
  .ser_out_n   (ser_out_n)
);

// File: tb/sim_piso_shifter.sv
module sim_piso_shifter;
  logic       clk = 1'b0;
  logic       load_n = 1'b0;
  logic       clk_inhibit = 1'b0;
  logic       ser_in = 1'b0;
  logic [7:0] par_in = 8'hA5;
  logic       ser_out;
  logic       ser_out_n;

  int    vectors = 0;
  int    miscompares = 0;
  string tag = "R2";
  bit    mq[$];

  always #10 clk = ~clk;

  piso_shifter u0 (
    .clk         (clk),
    .load_n      (load_n),
    .clk_inhibit (clk_inhibit),
    .ser_in      (ser_in),
    .par_in      (par_in),
    .ser_out     (ser_out),
    .ser_out_n   (ser_out_n)
  );

  // Behavioural reference: queue front is the bit nearest the output.
  always @(posedge clk) begin
    if (!load_n) begin
      mq = {};
      for (int i = 7; i >= 0; i--) mq.push_back(par_in[i]);
    end else if (!clk_inhibit && mq.size() == 8) begin
      void'(mq.pop_front());
      mq.push_back(ser_in);
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (mq.size() == 8) begin
      logic e;
      e = load_n ? mq[0] : par_in[7];
      check(tag, ser_out, e);
      check("R6", ser_out_n, ~e);
    end
  end

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_word(input logic [7:0] w, input logic inh);
    @(negedge clk);
    tag = inh ? "R8" : "R2";
    clk_inhibit = inh;
    par_in = w;
    load_n = 1'b0;
    #1 check("R1", ser_out, w[7]);
    edges(2);
    load_n = 1'b1;
  endtask

  initial begin
    #4000000;
    miscompares++;
    $display("FAIL watchdog: got hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    // Reset state: held in load, edges ignored (R2), output shows D7 (R1).
    edges(3);
    check("R1", ser_out, 1'b1);
    load_n = 1'b1;
    // Shift out A5 with zeros behind (R3, R7).
    tag = "R3";
    ser_in = 1'b0;
    edges(8);
    tag = "R7";
    edges(3);
    check("R7", ser_out, 1'b0);

    // Load under inhibit (R8), then frozen (R5).
    load_word(8'h3C, 1'b1);
    tag = "R5";
    edges(4);
    check("R5", ser_out, 1'b0);
    tag = "R3";
    clk_inhibit = 1'b0;
    edges(3);
    clk_inhibit = 1'b1;
    tag = "R5";
    edges(3);
    clk_inhibit = 1'b0;
    tag = "R3";
    edges(6);

    // Immediate load and tracking of parallel input (R1).
    @(negedge clk);
    par_in = 8'h81;
    load_n = 1'b0;
    #1 check("R1", ser_out, 1'b1);
    par_in = 8'h01;
    #1 check("R1", ser_out, 1'b0);
    par_in = 8'hFF;
    #1 check("R1", ser_out, 1'b1);
    tag = "R2";
    edges(3);
    load_n = 1'b1;
    tag = "R7";
    ser_in = 1'b1;
    edges(10);
    check("R7", ser_out, 1'b1);

    // Serial-in, serial-out pass-through (R4).
    load_word(8'h00, 1'b0);
    tag = "R4";
    for (int i = 0; i < 24; i++) begin
      ser_in = (i % 3 == 0);
      @(negedge clk);
    end

    // Mixed stimulus (R3, R5, R2).
    lfsr = 16'hACE1;
    tag = "R3";
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ser_in = lfsr[0];
      clk_inhibit = (lfsr[3:1] == 3'b000);
      if (lfsr[9:5] == 5'd0) begin
        load_word(lfsr[15:8], lfsr[4]);
        tag = "R3";
      end else begin
        @(negedge clk);
      end
    end
    edges(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule